// File: doc/BRIEF.md
# Lockable Monitor Configuration Bank

This block holds the configuration and threshold registers of a hardware-monitoring controller. Software reaches it through a plain synchronous register port: an address, write data and a write strobe, with read data returned combinationally for the current address. The bank holds one main configuration register, a maximum-duty register for each fan, and a set of threshold registers. Its outputs steer the fan PWM generators, the threshold comparators and the serial bus front end.

A sticky lock bit freezes every lockable register until the next reset. The monitor-enable bit and the full-speed bit stay writable after lock. While monitoring is off, every fan is forced to 100% duty and the comparators see the built-in default thresholds. The programmed thresholds are kept and come back into use as soon as monitoring is turned on again.

Top module: `hwmon_cfg_bank`

## Requirements
- R1: After reset the configuration register at 0x40 reads 0x04, every max-duty register reads 0xFF, every threshold register reads its default, `fan_force` is 1 and every fan duty is 0xFF.
- R2: While the monitor bit (config bit 0) is 0, `fan_force` is 1, every fan duty is 0xFF, and `lim_active` carries the default thresholds whatever values have been programmed.
- R3: While the monitor bit is 1, `lim_active` carries the programmed threshold registers (slot i at address 0x44+i, in bits i*8 upward).
- R4: With the monitor bit 1, full-speed (config bit 3) set gives `fan_force` 1 and duty of fan i equal to the max-duty register at 0x30+i. With full-speed clear, `fan_force` is 0 and the duty outputs still carry the max-duty values.
- R5: Once locked, writes to threshold registers, max-duty registers and the lockable config bits are ignored, and their read-back is unchanged until reset.
- R6: Writing 1 to config bit 1 sets the lock. Once set, it cannot be cleared by any write, and `locked` stays 1 until reset.
- R7: The monitor bit and the full-speed bit stay writable while locked.
- R8: Config bit 2 (ready) always reads 1 and ignores writes. Bits 7:6 are reserved, read 0 and ignore writes.
- R9: Config bit 4 drives `spinup_off` and config bit 5 drives `bus_to_en`. Both bits are lockable.
- R10: Reads from addresses outside 0x30..0x32, 0x40 and 0x44..0x47 return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also clears the lock |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe for the current address |
| rdata | output | 8 | Read data for the current address |
| fan_force | output | 1 | Fans run at the forced duty and ignore closed-loop control |
| fan_duty | output | 24 | Per-fan duty: 0xFF when monitoring is off, otherwise the max-duty value |
| lim_active | output | 32 | Thresholds in force: programmed or default |
| mon_en | output | 1 | Monitoring enabled |
| spinup_off | output | 1 | Hold PWM high for the full spin-up time instead of counting tach pulses |
| bus_to_en | output | 1 | Bus front end may release a stalled transaction |
| locked | output | 1 | Lock bit state |

## Verification
The embedded properties check every cycle that the lock never falls and that locked thresholds, duty caps and lockable config bits hold still. They also check that monitoring off always forces full duty, that full-speed passes the max-duty values through, and that the ready and reserved bits read correctly. Only the bench scenarios show the values involved: that thresholds programmed while monitoring was off return intact when it is turned on, that the exempt bits still toggle after lock, and that the defaults and address decode read back as stated.

// File: rtl/hwmon_cfg_bank.sv
module hwmon_cfg_bank #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int NUM_FANS = 3,
  parameter int NUM_LIMITS = 4,
  parameter logic [AW-1:0] CFG_ADDR = 8'h40,
  parameter logic [AW-1:0] MAX_BASE = 8'h30,
  parameter logic [AW-1:0] LIM_BASE = 8'h44,
  parameter logic [NUM_LIMITS*DW-1:0] LIM_DFLT = 32'h50463C28
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  input  logic                     we,
  output logic [DW-1:0]            rdata,
  output logic                     fan_force,
  output logic [NUM_FANS*DW-1:0]   fan_duty,
  output logic [NUM_LIMITS*DW-1:0] lim_active,
  output logic                     mon_en,
  output logic                     spinup_off,
  output logic                     bus_to_en,
  output logic                     locked
);

  logic mon_q, lock_q, full_q, spin_q, bus_q;
  logic [NUM_FANS-1:0][DW-1:0]   max_q;
  logic [NUM_LIMITS-1:0][DW-1:0] lim_q;

  wire cfg_hit = addr == CFG_ADDR;
  wire wr_lk   = we && !lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_q  <= 1'b0;
      lock_q <= 1'b0;
      full_q <= 1'b0;
      spin_q <= 1'b0;
      bus_q  <= 1'b0;
      for (int i = 0; i < NUM_FANS; i++) max_q[i] <= '1;
      for (int i = 0; i < NUM_LIMITS; i++) lim_q[i] <= LIM_DFLT[i*DW +: DW];
    end else begin
      if (we && cfg_hit) begin
        mon_q  <= wdata[0];
        full_q <= wdata[3];
        if (wdata[1]) lock_q <= 1'b1;
      end
      if (wr_lk && cfg_hit) begin
        spin_q <= wdata[4];
        bus_q  <= wdata[5];
      end
      for (int i = 0; i < NUM_FANS; i++)
        if (wr_lk && addr == MAX_BASE + AW'(i)) max_q[i] <= wdata;
      for (int i = 0; i < NUM_LIMITS; i++)
        if (wr_lk && addr == LIM_BASE + AW'(i)) lim_q[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (cfg_hit) rdata = DW'({2'b00, bus_q, spin_q, full_q, 1'b1, lock_q, mon_q});
    for (int i = 0; i < NUM_FANS; i++)
      if (addr == MAX_BASE + AW'(i)) rdata = max_q[i];
    for (int i = 0; i < NUM_LIMITS; i++)
      if (addr == LIM_BASE + AW'(i)) rdata = lim_q[i];
  end

  assign fan_force  = !mon_q || full_q;
  assign mon_en     = mon_q;
  assign spinup_off = spin_q;
  assign bus_to_en  = bus_q;
  assign locked     = lock_q;

  for (genvar g = 0; g < NUM_FANS; g++) begin : g_fan
    assign fan_duty[g*DW +: DW] = mon_q ? max_q[g] : '1;
  end
  for (genvar g = 0; g < NUM_LIMITS; g++) begin : g_lim
    assign lim_active[g*DW +: DW] = mon_q ? lim_q[g] : LIM_DFLT[g*DW +: DW];
  end

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(lim_q) && $stable(max_q)));
  p_locked_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(spinup_off) && $stable(bus_to_en)));
  p_mon_off_force_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |-> (fan_force && (&fan_duty)));
  p_full_speed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en && full_q) |-> (fan_force && fan_duty == max_q));
  p_ro_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |-> (rdata[2] && rdata[7:6] == 2'b00));

endmodule

// File: tb/hwmon_cfg_bank_tb.sv
`timescale 1ns/1ps
module hwmon_cfg_bank_tb_top;
  logic clk = 0, rst_n = 0, we = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic fan_force, mon_en, spinup_off, bus_to_en, locked;
  logic [23:0] fan_duty;
  logic [31:0] lim_active;
  int errs = 0, total = 0;
  bit done = 0;

  localparam logic [31:0] DFLT = 32'h50463C28;
  // {addr, wdata, expected read-back}
  localparam logic [23:0] VEC [11] = '{
    24'h30A0A0, 24'h318080, 24'h326060,
    24'h441111, 24'h452222, 24'h463333, 24'h474444,
    24'h40F034,   // R8: ready reads 1, reserved 7:6 read 0
    24'h400004,
    24'h509900,   // R10 unmapped
    24'h331200    // R10 just past the duty registers
  };

  always #2 clk = ~clk;

  hwmon_cfg_bank dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .we(we), .rdata(rdata), .fan_force(fan_force), .fan_duty(fan_duty),
    .lim_active(lim_active), .mon_en(mon_en), .spinup_off(spinup_off),
    .bus_to_en(bus_to_en), .locked(locked));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'h40, v); chk("R1 cfg", v, 8'h04);
    rd(8'h31, v); chk("R1 maxduty", v, 8'hFF);
    rd(8'h44, v); chk("R1 limit", v, 8'h28);
    chk("R1 force", fan_force, 1);
    chk("R1 duty", fan_duty, 24'hFFFFFF);
    chk("R1 lim_active", lim_active, DFLT);

    for (int k = 0; k < 11; k++) begin
      wr(VEC[k][23:16], VEC[k][15:8]);
      rd(VEC[k][23:16], v);
      chk("R10 readback", v, VEC[k][7:0]);
    end

    chk("R2 defaults while off", lim_active, DFLT);
    chk("R2 full duty while off", fan_duty, 24'hFFFFFF);
    wr(8'h40, 8'h01);
    chk("R3 programmed limits", lim_active, 32'h44332211);
    chk("R4 no force", fan_force, 0);
    chk("R4 duty cap", fan_duty, 24'h6080A0);
    wr(8'h40, 8'h09);
    chk("R4 full force", fan_force, 1);
    chk("R4 full duty", fan_duty, 24'h6080A0);
    wr(8'h40, 8'h08);
    chk("R2 off beats full", fan_duty, 24'hFFFFFF);
    wr(8'h40, 8'h31);
    chk("R9 outputs", {spinup_off, bus_to_en}, 2'b11);
    wr(8'h40, 8'h33);
    chk("R6 lock set", locked, 1);
    rd(8'h40, v); chk("R6 cfg locked", v, 8'h37);
    wr(8'h44, 8'hEE); rd(8'h44, v); chk("R5 limit frozen", v, 8'h11);
    wr(8'h30, 8'h01); rd(8'h30, v); chk("R5 maxduty frozen", v, 8'hA0);
    wr(8'h40, 8'h08);
    rd(8'h40, v); chk("R7 exempt bits move, R6 lock holds", v, 8'h3E);
    chk("R9 bits frozen", {spinup_off, bus_to_en}, 2'b11);
    chk("R2 defaults when off after lock", lim_active, DFLT);
    wr(8'h40, 8'h01);
    rd(8'h40, v); chk("R7 monitor back on", v, 8'h37);
    chk("R3 limits kept", lim_active, 32'h44332211);

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    rd(8'h40, v); chk("R1 cfg after reset", v, 8'h04);
    chk("R6 lock cleared by reset", locked, 0);
    wr(8'h44, 8'h77); rd(8'h44, v); chk("R5 writable after reset", v, 8'h77);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++; errs++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule